// File: doc/BRIEF.md
# Dual-Channel Serial ADC Capture Controller

This block sits between user logic and two external parts: a preamplifier whose gain is set over a serial link, and a two-channel serial converter that streams both samples back on one data line. One serial clock output is shared by both parts. The block first sends the gain word to the amplifier while holding the amplifier select low. After that it reports that it is ready. Each conversion request then produces a convert strobe and a fixed-length serial clock burst. During the burst the block captures two 14-bit samples.

The serial clock comes from the system clock through a divider set by `SCK_HALF`, the number of system cycles in each half period. The default of 2 gives a quarter of the system rate. Every output comes straight from a flop. Incoming data is sampled on the system edge at which the serial clock rises, so the data line may settle any time during the preceding low phase.

Top module: `dual_adc_capture`

## Requirements
- R1: While reset is held and in the first cycle after it, `ready`, `conv`, `sck` and `mosi` are 0, `amp_cs_n` is 1 and both samples are 0.
- R2: When `amp_en` is seen high after reset, `amp_cs_n` goes low and the 8-bit `gain` word is sent most significant bit first. Exactly 8 `sck` rising edges occur while `amp_cs_n` is low. `mosi` changes only when `sck` falls, never while `sck` stays high.
- R3: `amp_cs_n` returns high on the `sck` falling edge after the 8th rise. `ready` first rises exactly 2*SCK_HALF system cycles later.
- R4: While running, `sck` has a period of 2*SCK_HALF system cycles. It stays low whenever no transfer is in progress, including whenever `ready` is high.
- R5: A `start_conv` pulse seen while `ready` is high drops `ready` and raises `conv` at the next edge. `conv` stays high for exactly one cycle.
- R6: A `start_conv` pulse seen while `ready` is low is ignored. This covers pulses before configuration and pulses during a frame: no extra `conv` pulse and no serial clock result.
- R7: A frame holds exactly 34 `sck` rises, counted from `conv`. The first rise comes SCK_HALF cycles after `conv` falls.
- R8: `sample_a` holds the `miso` bits sampled on rises 3 to 16 of the frame, first bit as MSB.
- R9: `sample_b` holds the `miso` bits sampled on rises 19 to 32 of the frame, first bit as MSB. Rises 1, 2, 17, 18, 33 and 34 carry no data.
- R10: Both samples update together, only on the edge where `ready` rises: the `sck` falling edge after the 34th rise. At all other times they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| amp_en | input | 1 | Starts the one-time amplifier gain load |
| gain | input | 8 | Gain word, one 4-bit field per channel |
| start_conv | input | 1 | One-cycle conversion request |
| miso | input | 1 | Serial data from the converter |
| ready | output | 1 | Conversion may be requested |
| conv | output | 1 | One-cycle convert strobe |
| sample_a | output | 14 | Channel A result |
| sample_b | output | 14 | Channel B result |
| amp_cs_n | output | 1 | Amplifier select, active low |
| mosi | output | 1 | Serial gain data to the amplifier |
| sck | output | 1 | Shared serial clock |

## Verification
The `conv` strobe and the fall of `ready` are due one cycle after an accepted `start_conv`, so the bench samples them at the next falling clock edge. `conv` must be low again at the edge after that. A monitor timestamps every output event in system cycles, including `amp_cs_n` rising, `conv` falling, each `sck` rise and the rise of `ready`. The bench compares those differences with SCK_HALF, 2*SCK_HALF and the 34-rise frame length. It reads the samples only in the cycle where `ready` has just risen, and it flags any change to a sample in any other cycle.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAIN,
    ST_GAP,
    ST_READY,
    ST_CONV,
    ST_FRAME
  } cap_state_t;
endpackage

// File: rtl/adc_sck_div.sv
module adc_sck_div #(
  parameter int SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic sck,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(SCK_HALF + 1);
  localparam logic [CW-1:0] TOP = CW'(SCK_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          wrap;

  assign wrap = en && (cnt_q == TOP);
  assign rise = wrap && !sck_q;
  assign fall = wrap && sck_q;
  assign sck  = sck_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_half_period_r4: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && sck_q != $past(sck_q)) |-> ($past(cnt_q) == TOP));
endmodule

// File: rtl/adc_gain_tx.sv
module adc_gain_tx #(
  parameter int GAIN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [GAIN_W-1:0] gain,
  input  logic              rise,
  input  logic              fall,
  output logic              mosi,
  output logic              all_sent
);
  localparam int BW = $clog2(GAIN_W + 1);
  localparam logic [BW-1:0] NBITS = BW'(GAIN_W);

  logic [GAIN_W-1:0] sr_q;
  logic [BW-1:0]     sent_q;
  logic              mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      sent_q <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      sr_q   <= gain;
      sent_q <= '0;
      mosi_q <= gain[GAIN_W-1];
    end else begin
      if (rise && sent_q != NBITS) sent_q <= sent_q + 1'b1;
      if (fall) begin
        sr_q   <= {sr_q[GAIN_W-2:0], 1'b0};
        mosi_q <= sr_q[GAIN_W-2];
      end
    end
  end

  assign mosi     = mosi_q;
  assign all_sent = (sent_q == NBITS);

  p_bit_bound_r2: assert property (@(posedge clk) disable iff (rst)
    sent_q <= NBITS);
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx #(
  parameter int SAMPLE_W    = 14,
  parameter int A_FIRST     = 3,
  parameter int B_FIRST     = 19,
  parameter int FRAME_EDGES = 34
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                rise,
  input  logic                commit,
  input  logic                miso,
  output logic                last,
  output logic [SAMPLE_W-1:0] sample_a,
  output logic [SAMPLE_W-1:0] sample_b
);
  localparam int EW = $clog2(FRAME_EDGES + 1);
  localparam logic [EW-1:0] A_LO  = EW'(A_FIRST);
  localparam logic [EW-1:0] A_HI  = EW'(A_FIRST + SAMPLE_W - 1);
  localparam logic [EW-1:0] B_LO  = EW'(B_FIRST);
  localparam logic [EW-1:0] B_HI  = EW'(B_FIRST + SAMPLE_W - 1);
  localparam logic [EW-1:0] LASTE = EW'(FRAME_EDGES);

  logic [EW-1:0]       edge_q;
  logic [EW-1:0]       edge_nx;
  logic [SAMPLE_W-1:0] sh_a_q, sh_b_q, out_a_q, out_b_q;
  logic                in_a, in_b;

  assign edge_nx = edge_q + 1'b1;
  assign in_a    = (edge_nx >= A_LO) && (edge_nx <= A_HI);
  assign in_b    = (edge_nx >= B_LO) && (edge_nx <= B_HI);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      edge_q <= '0;
    end else if (rise && edge_q != LASTE) begin
      edge_q <= edge_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_a_q <= '0;
      sh_b_q <= '0;
    end else if (rise) begin
      if (in_a) sh_a_q <= {sh_a_q[SAMPLE_W-2:0], miso};
      if (in_b) sh_b_q <= {sh_b_q[SAMPLE_W-2:0], miso};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_a_q <= '0;
      out_b_q <= '0;
    end else if (commit) begin
      out_a_q <= sh_a_q;
      out_b_q <= sh_b_q;
    end
  end

  assign last     = (edge_q == LASTE);
  assign sample_a = out_a_q;
  assign sample_b = out_b_q;

  p_edge_bound_r7: assert property (@(posedge clk) disable iff (rst)
    edge_q <= LASTE);
  p_commit_at_end_r10: assert property (@(posedge clk) disable iff (rst)
    commit |-> last);
endmodule

// File: rtl/dual_adc_capture.sv
module dual_adc_capture #(
  parameter int SCK_HALF    = 2,
  parameter int GAIN_W      = 8,
  parameter int SAMPLE_W    = 14,
  parameter int A_FIRST     = 3,
  parameter int B_FIRST     = 19,
  parameter int FRAME_EDGES = 34
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                amp_en,
  input  logic [GAIN_W-1:0]   gain,
  input  logic                start_conv,
  input  logic                miso,
  output logic                ready,
  output logic                conv,
  output logic [SAMPLE_W-1:0] sample_a,
  output logic [SAMPLE_W-1:0] sample_b,
  output logic                amp_cs_n,
  output logic                mosi,
  output logic                sck
);
  import adc_cap_pkg::*;

  localparam int GW = $clog2(2 * SCK_HALF + 1);
  localparam logic [GW-1:0] GAP_END = GW'(2 * SCK_HALF - 1);

  cap_state_t    state_q;
  logic          sck_en_q, ready_q, conv_q, cs_n_q;
  logic [GW-1:0] gap_q;
  logic          rise, fall, all_sent, last;
  logic          load, accept, commit;

  assign load   = (state_q == ST_IDLE) && amp_en;
  assign accept = (state_q == ST_READY) && start_conv;
  assign commit = (state_q == ST_FRAME) && fall && last;

  adc_sck_div #(.SCK_HALF(SCK_HALF)) u_div (
    .clk (clk), .rst (rst), .en (sck_en_q),
    .sck (sck), .rise (rise), .fall (fall)
  );

  adc_gain_tx #(.GAIN_W(GAIN_W)) u_tx (
    .clk (clk), .rst (rst), .load (load), .gain (gain),
    .rise (rise), .fall (fall), .mosi (mosi), .all_sent (all_sent)
  );

  adc_frame_rx #(
    .SAMPLE_W (SAMPLE_W), .A_FIRST (A_FIRST),
    .B_FIRST (B_FIRST), .FRAME_EDGES (FRAME_EDGES)
  ) u_rx (
    .clk (clk), .rst (rst), .clear (accept), .rise (rise),
    .commit (commit), .miso (miso), .last (last),
    .sample_a (sample_a), .sample_b (sample_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      sck_en_q <= 1'b0;
      ready_q  <= 1'b0;
      conv_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      gap_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (load) begin
          cs_n_q   <= 1'b0;
          sck_en_q <= 1'b1;
          state_q  <= ST_GAIN;
        end
        ST_GAIN: if (fall && all_sent) begin
          cs_n_q   <= 1'b1;
          sck_en_q <= 1'b0;
          gap_q    <= '0;
          state_q  <= ST_GAP;
        end
        ST_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GAP_END) begin
            ready_q <= 1'b1;
            state_q <= ST_READY;
          end
        end
        ST_READY: if (accept) begin
          ready_q <= 1'b0;
          conv_q  <= 1'b1;
          state_q <= ST_CONV;
        end
        ST_CONV: begin
          conv_q   <= 1'b0;
          sck_en_q <= 1'b1;
          state_q  <= ST_FRAME;
        end
        ST_FRAME: if (commit) begin
          sck_en_q <= 1'b0;
          ready_q  <= 1'b1;
          state_q  <= ST_READY;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready    = ready_q;
  assign conv     = conv_q;
  assign amp_cs_n = cs_n_q;

  p_conv_single_r5: assert property (@(posedge clk) disable iff (rst)
    conv |=> !conv);
  p_start_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (ready && start_conv) |=> (conv && !ready));
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (!ready && start_conv) |=> !conv);
  p_sck_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    ready |-> !sck);
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));
  p_samples_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$rose(ready) |-> ($stable(sample_a) && $stable(sample_b)));
endmodule

// File: tb/dual_adc_capture_test.sv
module dual_adc_capture_test;
  localparam int HALF = 2;
  localparam int NV   = 5;
  // each entry: {non-data level, channel A, channel B}
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 14'h0000, 14'h3FFF},
    {1'b0, 14'h3FFF, 14'h0000},
    {1'b1, 14'h2AAA, 14'h1555},
    {1'b0, 14'h0001, 14'h2000},
    {1'b1, 14'h1234, 14'h0ABC}
  };

  logic clk = 1'b0, rst = 1'b1, amp_en = 1'b0, start_conv = 1'b0, miso = 1'b0;
  logic [7:0] gain = 8'h00;
  logic ready, conv, amp_cs_n, mosi, sck;
  logic [13:0] sample_a, sample_b;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  dual_adc_capture uut (
    .clk (clk), .rst (rst), .amp_en (amp_en), .gain (gain),
    .start_conv (start_conv), .miso (miso), .ready (ready), .conv (conv),
    .sample_a (sample_a), .sample_b (sample_b), .amp_cs_n (amp_cs_n),
    .mosi (mosi), .sck (sck)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor state
  logic [13:0] cur_a = '0, cur_b = '0;
  logic cur_fill = 1'b0;
  int cyc = 0, rise_cnt = 0, gain_rises = 0, period_err = 0, conv_pulses = 0;
  int last_rise = 0, conv_fall = 0, first_delay = -1, cs_rise = 0, rdy_rise = 0;
  logic [7:0] gain_bits = '0;
  logic sck_p = 1'b0, cs_p = 1'b1, conv_p = 1'b0, rdy_p = 1'b0, early = 1'b0;
  logic [13:0] a_p = '0, b_p = '0;

  function automatic logic bitval(input int e);
    if (e >= 3 && e <= 16) return cur_a[13 - (e - 3)];
    if (e >= 19 && e <= 32) return cur_b[13 - (e - 19)];
    return cur_fill;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (conv && !conv_p) begin
        conv_pulses++;
        rise_cnt = 0;
        first_delay = -1;
        miso = bitval(1);
      end
      if (!conv && conv_p) conv_fall = cyc;
      if (sck && !sck_p) begin
        if (!amp_cs_n) begin
          gain_bits = {gain_bits[6:0], mosi};
          gain_rises++;
        end else begin
          rise_cnt++;
          if (rise_cnt == 1) first_delay = cyc - conv_fall;
          else if (cyc - last_rise != 2 * HALF) period_err++;
          last_rise = cyc;
          miso = bitval(rise_cnt + 1);
        end
      end
      if (amp_cs_n && !cs_p) cs_rise = cyc;
      if (ready && !rdy_p) rdy_rise = cyc;
      if ((sample_a !== a_p || sample_b !== b_p) && !(ready && !rdy_p)) early = 1'b1;
    end
    sck_p = sck; cs_p = amp_cs_n; conv_p = conv; rdy_p = ready;
    a_p = sample_a; b_p = sample_b;
  end

  task automatic tick;
    @(negedge clk); #1;
  endtask

  task automatic wait_ready;
    while (ready !== 1'b1) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pulses_before;
    repeat (3) tick();
    chk(ready === 1'b0 && conv === 1'b0 && sck === 1'b0 && mosi === 1'b0, "R1 controls", int'(ready), 0);
    chk(amp_cs_n === 1'b1, "R1 cs", int'(amp_cs_n), 1);
    chk(sample_a === 14'd0 && sample_b === 14'd0, "R1 samples", int'(sample_a), 0);
    rst = 1'b0;
    tick();
    chk(ready === 1'b0 && amp_cs_n === 1'b1 && sample_a === 14'd0, "R1 after release", int'(ready), 0);

    // R6: start before configuration is ignored
    start_conv = 1'b1; tick(); start_conv = 1'b0;
    repeat (12) tick();
    chk(conv_pulses == 0, "R6 early start conv", conv_pulses, 0);
    chk(sck === 1'b0 && ready === 1'b0, "R6 early start sck", int'(sck), 0);

    // gain load
    gain = 8'hB4; tick();
    amp_en = 1'b1;
    wait_ready();
    chk(gain_rises == 8, "R2 rise count", gain_rises, 8);
    chk(gain_bits == 8'hB4, "R2 gain bits", int'(gain_bits), 8'hB4);
    chk(rdy_rise - cs_rise == 2 * HALF, "R3 cs to ready", rdy_rise - cs_rise, 2 * HALF);
    chk(sck === 1'b0, "R4 idle sck low", int'(sck), 0);

    for (int v = 0; v < NV; v++) begin
      wait_ready();
      {cur_fill, cur_a, cur_b} = VEC[v];
      early = 1'b0;
      period_err = 0;
      pulses_before = conv_pulses;
      start_conv = 1'b1; tick();
      chk(conv === 1'b1 && ready === 1'b0, "R5 strobe", int'(conv), 1);
      start_conv = 1'b0; tick();
      chk(conv === 1'b0, "R5 single cycle", int'(conv), 0);
      if (v == 2) begin
        repeat (20) tick();
        start_conv = 1'b1; tick(); start_conv = 1'b0;
      end
      wait_ready();
      chk(sample_a === cur_a, "R8 channel A", int'(sample_a), int'(cur_a));
      chk(sample_b === cur_b, "R9 channel B", int'(sample_b), int'(cur_b));
      chk(rise_cnt == 34 && first_delay == HALF, "R7 frame edges", rise_cnt, 34);
      chk(period_err == 0, "R4 sck period", period_err, 0);
      chk(!early && rdy_rise - last_rise == HALF, "R10 update timing", rdy_rise - last_rise, HALF);
      chk(conv_pulses == pulses_before + 1, "R6 mid-frame start", conv_pulses, pulses_before + 1);
    end

    // results hold while idle and ready
    repeat (10) tick();
    chk(sample_a === cur_a && !early && sck === 1'b0, "R10 hold", int'(sample_a), int'(cur_a));

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule